// File: doc/BRIEF.md
# Single/Half Precision Float Format Converter

This block converts floating-point numbers between the 32-bit IEEE single precision format and a 16-bit half format, in either direction, one operand per clock. A direction bit selects the conversion: narrowing a single value to half, or widening a half value to single. Narrowing rounds under one of four rounding modes. Widening is always exact.

Three control bits change how the half side is read and written. The first selects an alternative half layout in which the top exponent code holds ordinary numbers, and which has no infinities, NaNs or subnormals. The second is a flush-to-zero mode. The third makes every NaN result the default NaN. Exceptions never trap. Each result carries its own six exception flags, and a sticky copy of those flags gathers them until reset.

The result and its flags are registered once, so they appear one clock after the operand is accepted. A new operand can be accepted on every clock.

Top module: `fp_halfconv`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `out_valid`, `result`, `res_flags` and `sticky_flags` are all zero.
- R2: An operand presented with `in_valid` high produces its result, with `out_valid` high, exactly one clock later. A clock with `in_valid` low produces `out_valid` low one clock later. Back-to-back operands are accepted on every clock.
- R3: With `dir`=1 and the alternative layout off, `operand[15:0]` (sign bit 15, 5-bit exponent with bias 15 in bits 14:10, 10-bit fraction) widens exactly to single precision (sign bit 31, 8-bit exponent with bias 127 in bits 30:23, 23-bit fraction). This covers zeros, infinities, normals and subnormals. `operand[31:16]` is ignored, and widening sets no flags except those named in R7 and R9.
- R4: With `dir`=0, a single value is rounded to half using `rmode` 00 = nearest-even, 01 = toward +inf, 10 = toward -inf, 11 = toward zero. The result sits in `result[15:0]` with `result[31:16]` zero, and the inexact flag is set whenever discarded bits were nonzero.
- R5: In the IEEE half layout without flush-to-zero, a result smaller than 2^-14 becomes a correctly rounded subnormal (or zero, or the smallest normal). The underflow flag is set when such a tiny result is also inexact.
- R6: In the IEEE half layout, a rounded magnitude above 65504 gives infinity under nearest-even, under toward-zero it gives 0x7BFF, and under the directed modes it gives infinity when rounding away from zero and 0x7BFF otherwise. Sign is kept, and overflow and inexact are both set.
- R7: A NaN input yields a quiet NaN. Its payload is kept and its top fraction bit is forced to 1, or, with the default-NaN control set, the result is 0x7FC00000 for single or 0x7E00 for half. A NaN whose top fraction bit is 0 (signalling) sets invalid.
- R8: In the alternative layout, exponent code 31 holds normal values up to 131008 and exponent code 0 reads as a signed zero. When narrowing, an overflow or an infinity saturates to sign|0x7FFF and a NaN gives 0x0000, each setting only invalid. A tiny result becomes a signed zero with underflow and inexact set.
- R9: With flush-to-zero set, a subnormal input becomes a signed zero with input-flush set. When narrowing, a result smaller than 2^-14 becomes a signed zero with output-flush and underflow set, and this takes precedence over R8's tiny rule.
- R10: `res_flags`/`sticky_flags` bit 5 is invalid, bit 4 overflow, bit 3 underflow, bit 2 inexact, bit 1 input flush, bit 0 output flush. After each accepted operand, `sticky_flags` is its previous value ORed with that operand's flags, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this clock |
| dir | input | 1 | 0 = single to half, 1 = half to single |
| operand | input | 32 | Single operand, or half operand in bits 15:0 |
| rmode | input | 2 | Rounding mode for narrowing |
| alt_half | input | 1 | Select alternative half layout |
| ftz | input | 1 | Flush subnormal inputs and tiny results to zero |
| dnan | input | 1 | Return the default NaN for NaN inputs |
| out_valid | output | 1 | Result present this clock |
| result | output | 32 | Converted value |
| res_flags | output | 6 | Exception flags of the current result |
| sticky_flags | output | 6 | Accumulated exception flags |

## Verification
Widening is tried on all 65536 half encodings, each with a random choice of layout, flush and NaN controls and random upper operand bits. This separates subnormal normalisation, NaN quieting and the alternative exponent-31 reading. Narrowing is tried on directed values at every rounding-mode and control combination: exact ties, values just under and over 65504 and 131008, the smallest normal and subnormal halves, single subnormals, and signalling and quiet NaNs. These values show which way each mode breaks a tie and where overflow and tininess begin. Random singles whose exponents are concentrated near the half range, interleaved with idle clocks, then check rounding carries into the exponent, the accumulation of the sticky flags and the valid timing against a behavioural model that rounds by quotient and remainder.

// File: rtl/fpc_pkg.sv
// Package: shared format constants, rounding-mode encoding and the flag
// record used by the float format converter. Assumes IEEE single and a
// 16-bit half with 5-bit exponent.
package fpc_pkg;

    localparam int SGL_W    = 32;
    localparam int SGL_EW   = 8;
    localparam int SGL_FW   = 23;
    localparam int SGL_BIAS = 127;
    localparam int HLF_W    = 16;
    localparam int HLF_EW   = 5;
    localparam int HLF_FW   = 10;
    localparam int HLF_BIAS = 15;
    localparam int FLAG_W   = 6;

    // Derived widths
    localparam int SGL_MW   = SGL_FW + 1;          // mantissa with hidden bit
    localparam int NARROW_SH = SGL_FW - HLF_FW;    // 13: shift for a normal result

    localparam logic [SGL_W-1:0] SGL_DNAN = 32'h7FC0_0000;
    localparam logic [HLF_W-1:0] HLF_DNAN = 16'h7E00;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    // First member is the most significant bit: invalid = bit 5
    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
        logic in_flush;
        logic out_flush;
    } fpc_flags_t;

endpackage

// File: rtl/fpc_round.sv
// Module: align-and-round unit. Shifts a mantissa right by shamt, adds the
// exponent base scaled to the fraction position, then applies the rounding
// increment. A carry out of the fraction field lands in the exponent field.
// Assumes shamt never exceeds MANT_W + 1.
module fpc_round
    import fpc_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int SH_W   = 5,
    parameter int EB_W   = 5,
    parameter int FRAC_W = 10,
    parameter int OUT_W  = 16
) (
    input  logic              sign,
    input  rmode_e            rmode,
    input  logic [MANT_W-1:0] mant,
    input  logic [SH_W-1:0]   shamt,
    input  logic [EB_W-1:0]   ebase,
    output logic [OUT_W-1:0]  sum,
    output logic              lost
);
    localparam int EXT_W = 2 * MANT_W + 1;

    logic [EXT_W-1:0]  ext;
    logic [MANT_W-1:0] keep;
    logic              guard;
    logic              sticky;
    logic              inc;

    // Align: kept bits on top, guard bit next, sticky bits below
    always_comb ext = {mant, {(MANT_W + 1){1'b0}}} >> shamt;

    assign keep   = ext[EXT_W-1 -: MANT_W];
    assign guard  = ext[MANT_W];
    assign sticky = |ext[MANT_W-1:0];
    assign lost   = guard | sticky;

    // Decide the rounding increment from the mode
    always_comb begin
        case (rmode)
            RM_NEAR: inc = guard & (sticky | keep[0]);
            RM_UP:   inc = ~sign & (guard | sticky);
            RM_DOWN: inc = sign & (guard | sticky);
            default: inc = 1'b0;
        endcase
    end

    // Compose exponent base and kept mantissa, then round
    always_comb sum = OUT_W'({ebase, {FRAC_W{1'b0}}}) + OUT_W'(keep) + OUT_W'(inc);

endmodule

// File: rtl/fpc_narrow.sv
// Module: combinational single-to-half narrowing. Handles NaN, infinity,
// zero, flushing, overflow and tiny results for both half layouts.
// Tininess is judged before rounding.
module fpc_narrow
    import fpc_pkg::*;
(
    input  logic [SGL_W-1:0] op,
    input  rmode_e           rmode,
    input  logic             alt,
    input  logic             ftz,
    input  logic             dnan,
    output logic [HLF_W-1:0] res,
    output fpc_flags_t       flg
);
    localparam int EMIN_H = 1 - HLF_BIAS;               // -14
    localparam int EMAX_I = (1 << HLF_EW) - 2 - HLF_BIAS;  // 15
    localparam int EMAX_A = EMAX_I + 1;                 // 16
    localparam int SH_CAP = SGL_MW + 1;                 // 25
    localparam logic [HLF_W-2:0] MAG_INF  = 15'h7C00;
    localparam logic [HLF_W-2:0] MAG_IMAX = 15'h7BFF;
    localparam logic [HLF_W-2:0] MAG_AMAX = 15'h7FFF;

    logic              s;
    logic [SGL_EW-1:0] e8;
    logic [SGL_FW-1:0] f23;
    logic              is_emax;
    logic              is_emin;
    logic              fnz;
    logic signed [9:0] e_unb;
    logic signed [9:0] neg_m1;
    logic              tiny;
    logic              pre_ovf;
    logic              post_ovf;
    logic              to_inf;
    logic [4:0]        shamt;
    logic [4:0]        ebase;
    logic [SGL_MW-1:0] mant;
    logic [HLF_W-1:0]  sum;
    logic              lost;

    assign s       = op[SGL_W-1];
    assign e8      = op[SGL_W-2 -: SGL_EW];
    assign f23     = op[SGL_FW-1:0];
    assign is_emax = &e8;
    assign is_emin = ~|e8;
    assign fnz     = |f23;
    assign mant    = {~is_emin, f23};

    // Unbiased exponent; subnormal inputs sit at the minimum exponent
    always_comb begin
        e_unb  = is_emin ? -10'sd126 : ($signed({2'b00, e8}) - 10'sd127);
        neg_m1 = -e_unb - 10'sd1;
    end

    // Range classification before rounding
    always_comb begin
        tiny    = e_unb < 10'(EMIN_H);
        pre_ovf = alt ? (e_unb > 10'(EMAX_A)) : (e_unb > 10'(EMAX_I));
    end

    // Alignment amount and exponent base for the rounder
    always_comb begin
        if (tiny) begin
            shamt = (neg_m1 > 10'(SH_CAP)) ? 5'(SH_CAP) : 5'(neg_m1);
            ebase = '0;
        end else begin
            shamt = 5'(NARROW_SH);
            ebase = 5'(e_unb - 10'(EMIN_H));
        end
    end

    fpc_round #(
        .MANT_W (SGL_MW),
        .SH_W   (5),
        .EB_W   (5),
        .FRAC_W (HLF_FW),
        .OUT_W  (HLF_W)
    ) u_round (
        .sign  (s),
        .rmode (rmode),
        .mant  (mant),
        .shamt (shamt),
        .ebase (ebase),
        .sum   (sum),
        .lost  (lost)
    );

    // Overflow caused by the rounding carry, and its direction
    always_comb begin
        post_ovf = alt ? sum[HLF_W-1] : (sum >= {1'b0, MAG_INF});
        to_inf   = (rmode == RM_NEAR) || (rmode == RM_UP && !s) || (rmode == RM_DOWN && s);
    end

    // Select the encoded result and its flags
    always_comb begin
        res = '0;
        flg = '0;
        if (is_emax && fnz) begin
            flg.invalid = alt | ~f23[SGL_FW-1];
            if (alt)       res = '0;
            else if (dnan) res = HLF_DNAN;
            else           res = {s, 5'h1F, 1'b1, f23[SGL_FW-2 -: HLF_FW-1]};
        end else if (is_emax) begin
            if (alt) begin
                res         = {s, MAG_AMAX};
                flg.invalid = 1'b1;
            end else begin
                res = {s, MAG_INF};
            end
        end else if (is_emin && !fnz) begin
            res = {s, 15'h0};
        end else if (is_emin && ftz) begin
            res          = {s, 15'h0};
            flg.in_flush = 1'b1;
        end else if (pre_ovf || post_ovf) begin
            if (alt) begin
                res         = {s, MAG_AMAX};
                flg.invalid = 1'b1;
            end else begin
                res          = {s, to_inf ? MAG_INF : MAG_IMAX};
                flg.overflow = 1'b1;
                flg.inexact  = 1'b1;
            end
        end else if (tiny && ftz) begin
            res           = {s, 15'h0};
            flg.out_flush = 1'b1;
            flg.underflow = 1'b1;
        end else if (tiny && alt) begin
            res           = {s, 15'h0};
            flg.underflow = 1'b1;
            flg.inexact   = 1'b1;
        end else begin
            res           = {s, sum[HLF_W-2:0]};
            flg.inexact   = lost;
            flg.underflow = tiny & lost;
        end
    end

endmodule

// File: rtl/fpc_widen.sv
// Module: combinational half-to-single widening. Always exact. Normalises
// IEEE half subnormals with a leading-one search. In the alternative layout
// exponent code 31 is an ordinary normal and code 0 is a signed zero.
module fpc_widen
    import fpc_pkg::*;
(
    input  logic [HLF_W-1:0] op,
    input  logic             alt,
    input  logic             ftz,
    input  logic             dnan,
    output logic [SGL_W-1:0] res,
    output fpc_flags_t       flg
);
    localparam int EXP_SHIFT = SGL_BIAS - HLF_BIAS;          // 112
    localparam int DN_EXP0   = SGL_BIAS - HLF_BIAS - HLF_FW + 1;  // 103

    logic              s;
    logic [HLF_EW-1:0] e5;
    logic [HLF_FW-1:0] f10;
    logic [3:0]        lead;
    logic [SGL_FW-1:0] dn_frac;
    logic [SGL_EW-1:0] dn_exp;
    logic [SGL_EW-1:0] nrm_exp;

    assign s   = op[HLF_W-1];
    assign e5  = op[HLF_W-2 -: HLF_EW];
    assign f10 = op[HLF_FW-1:0];

    // Position of the highest set fraction bit
    always_comb begin
        lead = '0;
        for (int i = 0; i < HLF_FW; i++) begin
            if (f10[i]) lead = 4'(i);
        end
    end

    // Normalised subnormal fields and the rebiased normal exponent
    always_comb begin
        dn_frac = {{(SGL_FW - HLF_FW){1'b0}}, f10} << (5'(SGL_FW) - 5'(lead));
        dn_exp  = 8'(lead) + 8'(DN_EXP0);
        nrm_exp = {3'b000, e5} + 8'(EXP_SHIFT);
    end

    // Select the encoded result and its flags
    always_comb begin
        res = '0;
        flg = '0;
        if (alt) begin
            if (e5 == '0) res = {s, 31'h0};
            else          res = {s, nrm_exp, f10, 13'h0};
        end else if (&e5) begin
            if (f10 == '0) begin
                res = {s, 8'hFF, 23'h0};
            end else begin
                flg.invalid = ~f10[HLF_FW-1];
                res = dnan ? SGL_DNAN : {s, 8'hFF, 1'b1, f10[HLF_FW-2:0], 13'h0};
            end
        end else if (e5 == '0) begin
            if (f10 == '0) begin
                res = {s, 31'h0};
            end else if (ftz) begin
                res          = {s, 31'h0};
                flg.in_flush = 1'b1;
            end else begin
                res = {s, dn_exp, dn_frac};
            end
        end else begin
            res = {s, nrm_exp, f10, 13'h0};
        end
    end

endmodule

// File: rtl/fp_halfconv.sv
// Module: top of the single/half float converter. Selects the narrowing or
// widening datapath with dir, registers the result and its flags once, and
// keeps sticky flags until reset. Synchronous active-low reset.
module fp_halfconv
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir,
    input  logic [SGL_W-1:0]  operand,
    input  logic [1:0]        rmode,
    input  logic              alt_half,
    input  logic              ftz,
    input  logic              dnan,
    output logic              out_valid,
    output logic [SGL_W-1:0]  result,
    output logic [FLAG_W-1:0] res_flags,
    output logic [FLAG_W-1:0] sticky_flags
);
    logic [HLF_W-1:0]  n_res;
    fpc_flags_t        n_flg;
    logic [SGL_W-1:0]  w_res;
    fpc_flags_t        w_flg;
    logic [SGL_W-1:0]  nxt_res;
    logic [FLAG_W-1:0] nxt_flg;

    fpc_narrow u_narrow (
        .op    (operand),
        .rmode (rmode_e'(rmode)),
        .alt   (alt_half),
        .ftz   (ftz),
        .dnan  (dnan),
        .res   (n_res),
        .flg   (n_flg)
    );

    fpc_widen u_widen (
        .op   (operand[HLF_W-1:0]),
        .alt  (alt_half),
        .ftz  (ftz),
        .dnan (dnan),
        .res  (w_res),
        .flg  (w_flg)
    );

    // Pick the datapath for the requested direction
    always_comb begin
        if (dir) begin
            nxt_res = w_res;
            nxt_flg = w_flg;
        end else begin
            nxt_res = {{(SGL_W - HLF_W){1'b0}}, n_res};
            nxt_flg = n_flg;
        end
    end

    // Output stage: one-clock latency plus sticky flag accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            res_flags    <= '0;
            sticky_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= nxt_res;
                res_flags    <= nxt_flg;
                sticky_flags <= sticky_flags | nxt_flg;
            end
        end
    end

endmodule

// File: rtl/fpc_checker.sv
// Module: property checker for fp_halfconv, bound to every instance.
// Observes ports only.
module fpc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        dir,
    input logic        alt_half,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [5:0]  res_flags,
    input logic [5:0]  sticky_flags
);
    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_flags & $past(sticky_flags)) == $past(sticky_flags)); // R10

    AST_STICKY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((sticky_flags & res_flags) == res_flags)); // R10

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !$past(dir)) |-> (result[31:16] == 16'h0)); // R4

    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_flags[4]) |-> (res_flags[2] && !$past(alt_half))); // R6

    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (res_flags[1] || res_flags[0]))
            |-> ($past(dir) ? (result[30:0] == 31'h0) : (result[14:0] == 15'h0))); // R9

endmodule

bind fp_halfconv fpc_checker u_fpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .dir          (dir),
    .alt_half     (alt_half),
    .out_valid    (out_valid),
    .result       (result),
    .res_flags    (res_flags),
    .sticky_flags (sticky_flags)
);

// File: tb/fp_halfconv_test.sv
module fp_halfconv_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 160000;
    localparam int N_RANDOM = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  rmode = '0;
    logic        alt_half = 1'b0;
    logic        ftz = 1'b0;
    logic        dnan = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [5:0]  res_flags;
    logic [5:0]  sticky_flags;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit          v;
        logic [31:0] r;
        logic [5:0]  fl;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [5:0]  sticky_m = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_halfconv uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .dir          (dir),
        .operand      (operand),
        .rmode        (rmode),
        .alt_half     (alt_half),
        .ftz          (ftz),
        .dnan         (dnan),
        .out_valid    (out_valid),
        .result       (result),
        .res_flags    (res_flags),
        .sticky_flags (sticky_flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference: single to half by integer quotient and remainder
    function automatic exp_t ref_s2h(logic [31:0] x, logic [1:0] rm, logic a, logic fz, logic dn);
        exp_t e;
        logic s;
        int ex8, ex, top, qe, k, e5, lim;
        logic [22:0] fr;
        longint m, quo, rem, half, frac;
        bit up, to_inf;
        e.v = 1; e.fl = '0; e.r = '0; e.tag = "R4";
        s = x[31]; ex8 = int'(x[30:23]); fr = x[22:0];
        lim = a ? 31 : 30;
        if (ex8 == 255 && fr != 0) begin
            e.tag = a ? "R8" : "R7";
            e.fl[5] = a || !fr[22];
            e.r = a ? 32'h0 : (dn ? 32'h7E00 : {16'h0, s, 5'h1F, 1'b1, fr[21:13]});
        end else if (ex8 == 255) begin
            if (a) begin e.tag = "R8"; e.r = {16'h0, s, 15'h7FFF}; e.fl[5] = 1; end
            else begin e.tag = "R6"; e.r = {16'h0, s, 15'h7C00}; end
        end else if (ex8 == 0 && fr == 0) begin
            e.r = {16'h0, s, 15'h0};
        end else if (ex8 == 0 && fz) begin
            e.tag = "R9"; e.r = {16'h0, s, 15'h0}; e.fl[1] = 1;
        end else begin
            m  = (ex8 == 0) ? longint'(fr) : longint'(fr) + (64'sd1 <<< 23);
            ex = (ex8 == 0) ? -149 : ex8 - 150;
            top = ex;
            for (longint t = m; t > 1; t = t >>> 1) top++;
            if (top < -14 && fz) begin
                e.tag = "R9"; e.r = {16'h0, s, 15'h0}; e.fl[0] = 1; e.fl[3] = 1;
            end else if (top < -14 && a) begin
                e.tag = "R8"; e.r = {16'h0, s, 15'h0}; e.fl[3] = 1; e.fl[2] = 1;
            end else begin
                qe = (top < -14) ? -24 : top - 10;
                k = qe - ex;
                if (k > 40) begin
                    quo = 0; rem = m; half = 64'sd1 <<< 40;
                end else begin
                    quo = m >>> k; rem = m - (quo <<< k); half = 64'sd1 <<< (k - 1);
                end
                case (rm)
                    2'b00: up = (rem > half) || (rem == half && quo[0]);
                    2'b01: up = !s && rem != 0;
                    2'b10: up = s && rem != 0;
                    default: up = 0;
                endcase
                quo = quo + longint'(up);
                if (quo == 2048) begin quo = 1024; qe++; end
                e5 = (quo < 1024) ? 0 : qe + 25;
                if (e5 > lim) begin
                    if (a) begin
                        e.tag = "R8"; e.r = {16'h0, s, 15'h7FFF}; e.fl[5] = 1;
                    end else begin
                        to_inf = (rm == 2'b00) || (rm == 2'b01 && !s) || (rm == 2'b10 && s);
                        e.tag = "R6";
                        e.r = {16'h0, s, to_inf ? 15'h7C00 : 15'h7BFF};
                        e.fl[4] = 1; e.fl[2] = 1;
                    end
                end else begin
                    frac = (quo < 1024) ? quo : quo - 1024;
                    e.r = {16'h0, s, 5'(e5), 10'(frac)};
                    e.fl[2] = (rem != 0);
                    e.fl[3] = (top < -14) && (rem != 0);
                    e.tag = (top < -14) ? "R5" : "R4";
                end
            end
        end
        return e;
    endfunction

    // Reference: half to single by value normalisation
    function automatic exp_t ref_h2s(logic [31:0] x, logic a, logic fz, logic dn);
        exp_t e;
        logic s;
        int e5, m, ex;
        logic [9:0] f;
        e.v = 1; e.fl = '0; e.r = '0; e.tag = "R3";
        s = x[15]; e5 = int'(x[14:10]); f = x[9:0];
        if (a) begin
            e.tag = "R8";
            e.r = (e5 == 0) ? {s, 31'h0} : {s, 8'(e5 + 112), f, 13'h0};
        end else if (e5 == 31) begin
            if (f == 0) e.r = {s, 8'hFF, 23'h0};
            else begin
                e.tag = "R7"; e.fl[5] = !f[9];
                e.r = dn ? 32'h7FC0_0000 : {s, 8'hFF, 1'b1, f[8:0], 13'h0};
            end
        end else if (e5 == 0) begin
            if (f == 0) e.r = {s, 31'h0};
            else if (fz) begin e.tag = "R9"; e.r = {s, 31'h0}; e.fl[1] = 1; end
            else begin
                m = int'(f); ex = -24;
                while (m < 1024) begin m = m * 2; ex--; end
                e.r = {s, 8'(ex + 137), 10'(m - 1024), 13'h0};
            end
        end else begin
            e.r = {s, 8'(e5 + 112), f, 13'h0};
        end
        return e;
    endfunction

    // Compare the output visible now against the oldest expectation
    task automatic compare();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        chk(out_valid === e.v, "R2", {31'h0, out_valid}, {31'h0, e.v});
        if (e.v) begin
            sticky_m = sticky_m | e.fl;
            chk(result === e.r, e.tag, result, e.r);
            chk(res_flags === e.fl, e.tag, {26'h0, res_flags}, {26'h0, e.fl});
        end
        chk(sticky_flags === sticky_m, "R10", {26'h0, sticky_flags}, {26'h0, sticky_m});
    endtask

    task automatic step(input bit v, input bit d, input logic [31:0] x, input logic [1:0] rm,
                        input bit a, input bit fz, input bit dn);
        exp_t e;
        @(negedge clk);
        compare();
        in_valid = v; dir = d; operand = x; rmode = rm;
        alt_half = a; ftz = fz; dnan = dn;
        if (v) e = d ? ref_h2s(x, a, fz, dn) : ref_s2h(x, rm, a, fz, dn);
        else begin e.v = 0; e.r = '0; e.fl = '0; e.tag = "R2"; end
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst_n = 0; in_valid = 0;
        q.delete();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R1", {31'h0, out_valid}, 32'h0);
            chk(result === 32'h0, "R1", result, 32'h0);
            chk(res_flags === 6'h0 && sticky_flags === 6'h0, "R1",
                {20'h0, res_flags, sticky_flags}, 32'h0);
        end
        rst_n = 1;
        sticky_m = '0;
        @(negedge clk);
        chk(out_valid === 1'b0 && sticky_flags === 6'h0, "R1",
            {25'h0, out_valid, sticky_flags}, 32'h0);
    endtask

    logic [31:0] dvec [28] = '{
        32'h3F800000, 32'h477FE000, 32'h477FF000, 32'h47800000,
        32'h387FC000, 32'h38800000, 32'h33800000, 32'h33000000,
        32'h33000001, 32'h00000001, 32'h007FFFFF, 32'h7F800000,
        32'hFF800000, 32'h7FC00001, 32'h7F800001, 32'hFFA00000,
        32'h80000000, 32'h3F801000, 32'h3F803000, 32'hC77FF000,
        32'h47FFE000, 32'h47FFF000, 32'h48000000, 32'h7F7FFFFF,
        32'h3DCCCCCD, 32'hC0490FDB, 32'h387FE000, 32'hB8000000
    };

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R4 R5 R6 R7 R8 R9: directed narrowing over every mode and control
        for (int v = 0; v < 28; v++) begin
            for (int c = 0; c < 32; c++) begin
                step(1, 0, dvec[v], 2'(c), c[2], c[3], c[4]);
            end
        end
        step(0, 0, 32'h0, 2'b00, 0, 0, 0);

        // R3 R7 R8 R9: every half encoding widened, upper operand bits random
        for (int h = 0; h < 65536; h++) begin
            logic [31:0] x;
            x = {16'($urandom), 16'(h)};
            step(1, 1, x, 2'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0);
        end
        step(0, 0, 32'h0, 2'b00, 0, 0, 0);

        // R1: reset clears accumulated sticky flags
        do_reset();

        // R2 R4 R5 R6 R10: random narrowing with idle gaps
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [31:0] x;
            x = $urandom;
            if ($urandom % 2 == 0) x[30:23] = 8'(95 + $urandom % 65);
            else if ($urandom % 16 == 0) x[30:23] = 8'h00;
            if ($urandom % 7 == 0) step(0, 0, x, 2'b00, 0, 0, 0);
            step(1, 0, x, 2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
        end
        step(0, 0, 32'h0, 2'b00, 0, 0, 0);
        step(0, 0, 32'h0, 2'b00, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule